// File: doc/BRIEF.md
# Debounced Single-Pulse Generator

The block turns one operation of a mechanical contact into exactly one active-high output pulse of fixed width. Two identical debounce integrators sit in series on one clock. The first one cleans the raw contact level. It changes its output only after it has seen the new level on four consecutive clock samples, and any sample that disagrees restarts the count. The second integrator takes the cleaned level and delays it by a further four clocks. The pulse is the NOR of the two stage levels with one of them inverted. It is therefore high for exactly the four clocks in which the two stages disagree.

A trigger select input chooses the edge. With the select low, the pulse follows contact closure (make). With the select high, the pulse follows contact release (break). The select is captured only while both stages agree, so a change made while a pulse is in flight takes effect only after that pulse ends. The contact input is taken as synchronous to the clock, with 1 meaning closed.

Top module: `bounce_pulse_gen`

## Requirements
- R1: After reset both stage levels are open, `pulse_o` is 0, and no pulse appears while the contact stays open.
- R2: In make mode (`mode_i` = 0), if the contact is first sampled closed at clock edge k and stays closed, `pulse_o` goes high right after edge k+3.
- R3: Every pulse is high for exactly 4 consecutive clock cycles, because the second stage follows the first with a lag of exactly 4 clocks.
- R4: A closure preceded by bounce yields exactly one pulse. Each run of fewer than 4 equal samples restarts the count, and the pulse rises 3 edges after the first edge of the final clean run.
- R5: A closure that lasts fewer than 4 samples produces no pulse.
- R6: In break mode (`mode_i` = 1), if the contact is first sampled open at edge m after a settled closure, `pulse_o` goes high right after edge m+3 and stays high for 4 cycles.
- R7: Make mode gives no pulse on release, and break mode gives no pulse on closure.
- R8: A change of `mode_i` while a pulse is high neither cuts nor stretches that pulse. The new mode governs the next contact operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock shared by both stages |
| rst_ni | input | 1 | Asynchronous reset, active low |
| contact_i | input | 1 | Raw contact level, 1 = closed |
| mode_i | input | 1 | Trigger select: 0 = make, 1 = break |
| pulse_o | output | 1 | One 4-clock high pulse per contact operation |

## Verification
The bench checks the exact cycle of the pulse rise. A stage that counted 3 or 5 samples, or registered its output once more, would move the rise by a cycle. The bench feeds bounce runs of 1, 2 and 3 closed samples before a clean closure. A counter that did not restart on a disagreeing sample would fire early or fire twice. It also checks a 3-sample closure, which must give no pulse, and it checks that the edge opposite the selected one stays quiet. Last, it flips the select in the middle of a pulse. A design that used the select directly would cut the pulse short or add a stray pulse on release.

// File: rtl/bounce_pulse_gen_pkg.sv
package bounce_pulse_gen_pkg;
  typedef enum logic {
    TRIG_MAKE  = 1'b0,
    TRIG_BREAK = 1'b1
  } trig_e;
endpackage

// File: rtl/debounce_stage.sv
module debounce_stage #(
  parameter int SAMPLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic level_o
);
  localparam int CNT_W = (SAMPLES > 2) ? $clog2(SAMPLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLES - 1);

  logic             level_q;
  logic [CNT_W-1:0] cnt_q;

  // count consecutive disagreeing samples; any agreeing sample restarts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
      cnt_q   <= '0;
    end else if (in_i == level_q) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      level_q <= in_i;
      cnt_q   <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign level_o = level_q;
endmodule

// File: rtl/pulse_former.sv
module pulse_former
  import bounce_pulse_gen_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  mode_i,
  input  logic  lead_i,
  input  logic  lag_i,
  output trig_e mode_o,
  output logic  pulse_o
);
  trig_e mode_q;
  logic  idle;

  assign idle = (lead_i == lag_i);

  // select is only captured between pulses
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_q <= TRIG_MAKE;
    else if (idle) mode_q <= trig_e'(mode_i);
  end

  // inverter on one stage, then NOR with the other
  always_comb begin
    if (mode_q == TRIG_MAKE) pulse_o = ~((~lead_i) | lag_i);
    else                     pulse_o = ~(lead_i | (~lag_i));
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/bounce_pulse_gen.sv
module bounce_pulse_gen
  import bounce_pulse_gen_pkg::*;
#(
  parameter int SAMPLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic contact_i,
  input  logic mode_i,
  output logic pulse_o
);
  localparam int STAGES = 2;

  logic [STAGES:0] chain;
  trig_e           mode_q;

  assign chain[0] = contact_i;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    debounce_stage #(.SAMPLES(SAMPLES)) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .in_i   (chain[g]),
      .level_o(chain[g+1])
    );
  end

  pulse_former u_form (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_i),
    .lead_i (chain[1]),
    .lag_i  (chain[STAGES]),
    .mode_o (mode_q),
    .pulse_o(pulse_o)
  );
endmodule

// File: rtl/bounce_pulse_gen_chk.sv
module bounce_pulse_gen_chk #(
  parameter int SAMPLES = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pulse_o,
  input logic lead_i,
  input logic lag_i,
  input logic mode_q_i
);
  logic [15:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= '0;
    else if (pulse_o) run_q <= run_q + 1'b1;
    else              run_q <= '0;
  end

  // R3
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_o) |-> run_q == 16'(SAMPLES));

  // R3
  lag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lead_i == lag_i) |=> $stable(lag_i));

  // R7
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lead_i == lag_i) |-> !pulse_o);

  // R1
  rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |-> (lead_i != lag_i));

  // R8
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lead_i != lag_i) |=> $stable(mode_q_i));
endmodule

bind bounce_pulse_gen bounce_pulse_gen_chk #(.SAMPLES(SAMPLES)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pulse_o (pulse_o),
  .lead_i  (chain[1]),
  .lag_i   (chain[2]),
  .mode_q_i(mode_q)
);

// File: tb/bounce_pulse_gen_test.sv
`timescale 1ns/1ps
module bounce_pulse_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic contact = 1'b0;
  logic mode = 1'b0;
  logic pulse;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int rises = 0;
  int last_rise = -1;
  int last_width = -1;
  int width_cur = 0;
  logic prev_pulse = 1'b0;
  bit done = 1'b0;

  bounce_pulse_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .contact_i(contact),
    .mode_i(mode), .pulse_o(pulse)
  );

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // observe away from the active edge
  always @(negedge clk) begin
    if (pulse && !prev_pulse) begin
      rises++;
      last_rise = cyc;
      width_cur = 1;
    end else if (pulse) begin
      width_cur++;
    end else if (prev_pulse) begin
      last_width = width_cur;
    end
    prev_pulse = pulse;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic v);
    @(negedge clk);
    contact = v;
  endtask

  // drive v for n cycles; returns the first sampling edge
  task automatic hold(input logic v, input int n, output int first_edge);
    @(negedge clk);
    contact = v;
    first_edge = cyc + 1;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic settle_open();
    int e;
    hold(1'b0, 14, e);
  endtask

  task automatic t_reset();
    int r0;
    chk(pulse == 1'b0, "R1 reset pulse", pulse, 0);
    r0 = rises;
    repeat (12) @(negedge clk);
    chk(rises == r0, "R1 idle after reset", rises - r0, 0);
  endtask

  task automatic t_clean_make();
    int r0, e;
    mode = 1'b0;
    settle_open();
    r0 = rises;
    hold(1'b1, 14, e);
    chk(rises - r0 == 1, "R2 one pulse on make", rises - r0, 1);
    chk(last_rise == e + 3, "R2 rise cycle", last_rise, e + 3);
    chk(last_width == 4, "R3 width", last_width, 4);
    r0 = rises;
    hold(1'b0, 14, e);
    chk(rises == r0, "R7 no pulse on release in make mode", rises - r0, 0);
  endtask

  task automatic t_bounce();
    int r0, e;
    mode = 1'b0;
    settle_open();
    r0 = rises;
    drive(1); drive(0); drive(1); drive(1); drive(0);
    drive(1); drive(1); drive(1); drive(0);
    hold(1'b1, 14, e);
    chk(rises - r0 == 1, "R4 one pulse despite bounce", rises - r0, 1);
    chk(last_rise == e + 3, "R4 rise after clean run", last_rise, e + 3);
    chk(last_width == 4, "R3 width after bounce", last_width, 4);
    r0 = rises;
    drive(0); drive(1); drive(0); drive(0); drive(1);
    hold(1'b0, 14, e);
    chk(rises == r0, "R4 bounced release no pulse", rises - r0, 0);
  endtask

  task automatic t_short();
    int r0, e;
    mode = 1'b0;
    settle_open();
    r0 = rises;
    hold(1'b1, 3, e);
    hold(1'b0, 14, e);
    chk(rises == r0, "R5 short closure", rises - r0, 0);
    chk(pulse == 1'b0, "R5 output low", pulse, 0);
  endtask

  task automatic t_break();
    int r0, e;
    mode = 1'b1;
    settle_open();
    r0 = rises;
    hold(1'b1, 14, e);
    chk(rises == r0, "R7 no pulse on closure in break mode", rises - r0, 0);
    hold(1'b0, 14, e);
    chk(rises - r0 == 1, "R6 one pulse on release", rises - r0, 1);
    chk(last_rise == e + 3, "R6 rise cycle", last_rise, e + 3);
    chk(last_width == 4, "R6 width", last_width, 4);
    mode = 1'b0;
  endtask

  task automatic t_mode_mid();
    int r0, e;
    mode = 1'b0;
    settle_open();
    r0 = rises;
    hold(1'b1, 5, e);
    chk(pulse == 1'b1, "R8 pulse in flight", pulse, 1);
    mode = 1'b1;
    repeat (9) @(negedge clk);
    chk(rises - r0 == 1, "R8 one pulse", rises - r0, 1);
    chk(last_width == 4, "R8 width kept", last_width, 4);
    r0 = rises;
    hold(1'b0, 14, e);
    chk(rises - r0 == 1, "R8 new mode on release", rises - r0, 1);
    chk(last_rise == e + 3, "R8 release rise cycle", last_rise, e + 3);
    mode = 1'b0;
    settle_open();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_clean_make();
    t_bounce();
    t_short();
    t_break();
    t_mode_mid();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule